// File: doc/BRIEF.md
# Three-Axis Selectable High-Pass Filter

This block takes signed 8-bit acceleration samples for three axes, one set per strobe on `smp_valid`, and strips the slowly varying offset from each axis with a first-order high-pass stage. The stage tracks a running baseline per axis. The baseline moves toward each new sample by a fraction 1/coeff of the gap. The filtered value is the sample minus the baseline, clipped to 8 signed bits. A 2-bit cutoff field chooses coeff, which sets the corner frequency to the sample rate divided by 6·coeff. With a 100 Hz sample rate the corners are 2, 1, 0.5 and 0.25 Hz. With a 400 Hz sample rate they are 8, 4, 2 and 1 Hz.

The block feeds three downstream consumers: the output data registers and two threshold-interrupt engines. Each consumer has its own select bit that picks either the raw sample or the filtered sample. A one-cycle flush strobe discards the filter state at once. The next accepted sample then becomes the new baseline, so every axis reads exactly 0 on that sample and the filter needs no settling time.

Axis `a` (0 = X, 1 = Y, 2 = Z) sits at bits `[8a+7:8a]` of every three-axis bus. Engine `e` sits at bits `[24e+23:24e]` of `eng_data`, and bit `e` of `eng_filt` selects its source.

Top module: `tri_axis_hpf`

## Requirements
- R1: Reset behaviour.
  - While `rst_n` is low, `out_valid`, `out_data` and `eng_data` are all 0.
  - The first sample accepted after reset seeds the filter in the same way as a flush (R5).
- R2: Output timing and hold.
  - `out_valid` is high in exactly the cycle that follows each cycle where `smp_valid` is high.
  - `out_data` and `eng_data` change only in that cycle.
- R3: Filter arithmetic for an unseeded sample `x`, with baseline `b` held in units of 1/256.
  - The filtered value is `sat8(x − floor(b/256))`.
  - The baseline then becomes `b + floor((256·x − b) / 2^k)`.
  - `k` = 3 + `cut_sel`, so `cut_sel` 00, 01, 10 and 11 give coeff 8, 16, 32 and 64.
- R4: The filter state changes only on cycles where `smp_valid` is high, except for a flush.
  - Cutoff changes and sample values presented without `smp_valid` have no effect on later results.
- R5: Flush behaviour.
  - A `flush` pulse makes the next accepted sample, or a sample accepted in the same cycle as the pulse, produce filtered value 0 on every axis.
  - That sample also becomes the new baseline.
- R6: Output register source.
  - With `out_filt` = 0, `out_data` receives the raw sample.
  - With `out_filt` = 1, `out_data` receives the filtered sample.
  - The select bit is taken from the cycle of the sample.
- R7: Engine source.
  - `eng_filt[0]` selects raw (0) or filtered (1) data for engine 0.
  - `eng_filt[1]` does the same for engine 1.
  - The two bits act independently of each other and of `out_filt`.
- R8: Saturation.
  - A filtered value below −128 reads −128 (0x80).
  - A filtered value above 127 reads 127 (0x7F).
- R9: Axis independence.
  - Each axis keeps its own baseline.
  - One axis's data never affects another axis's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A sample set is present this cycle |
| smp_data | input | 24 | Signed samples, axis `a` at `[8a+7:8a]` |
| cut_sel | input | 2 | Cutoff code; coeff = 2^(3+code) |
| flush | input | 1 | Clear filter state; next sample seeds the baseline |
| out_filt | input | 1 | Output register source: 0 raw, 1 filtered |
| eng_filt | input | 2 | Per-engine source: bit e = 1 means filtered |
| out_valid | output | 1 | Outputs updated this cycle |
| out_data | output | 24 | Output register data, three axes |
| eng_data | output | 48 | Engine data, engine e at `[24e+23:24e]` |

## Verification
The hardest situations to reach from the ports are saturation on both sides of the range and a flush that lands in the same cycle as a sample. Saturation needs a baseline pinned at one end of the range and a sample at the other. Random data almost never sets this up. The bench therefore forces it with directed flush-and-seed sequences at −128 and +127, followed by the opposite extreme. Constrained random traffic then mixes idle gaps, cutoff changes, flushes with and without a coincident sample, and all source-select combinations. Every result is compared with a floor-division model of the baseline kept in the bench.

// File: rtl/tahp_pkg.sv
package tahp_pkg;
  // smallest shift of the baseline update; cutoff code adds to it
  localparam int unsigned SHIFT_MIN = 3;

  typedef enum logic {
    SRC_RAW  = 1'b0,
    SRC_FILT = 1'b1
  } src_sel_e;
endpackage

// File: rtl/hpf_axis.sv
module hpf_axis
  import tahp_pkg::*;
#(
  parameter int DW = 8,
  parameter int FB = 8,
  parameter int CW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic                 seed_req,
  input  logic signed [DW-1:0] smp,
  input  logic [CW-1:0]        shift_code,
  output logic signed [DW-1:0] hp,
  output logic                 seed_take
);
  localparam int AW = DW + FB;
  localparam int EW = AW + 2;
  localparam int SW = $clog2(EW) + 1;

  logic signed [AW-1:0] base_q;
  logic                 armed_q;
  logic signed [DW-1:0] base_int;
  logic signed [DW+1:0] diff;
  logic signed [EW-1:0] smp_wide;
  logic signed [EW-1:0] base_wide;
  logic signed [EW-1:0] delta;
  logic signed [EW-1:0] step;
  logic signed [EW-1:0] base_sum;
  logic [SW-1:0]        shamt;

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [DW+1:0] v);
    if ((v[DW+1] == v[DW]) && (v[DW] == v[DW-1])) return v[DW-1:0];
    else if (v[DW+1]) return {1'b1, {(DW-1){1'b0}}};
    else return {1'b0, {(DW-1){1'b1}}};
  endfunction

  assign seed_take = armed_q | seed_req;
  assign base_int  = base_q[AW-1:FB];
  assign diff      = $signed({{2{smp[DW-1]}}, smp}) - $signed({{2{base_int[DW-1]}}, base_int});
  assign hp        = seed_take ? '0 : sat_dw(diff);

  assign shamt     = SW'(SHIFT_MIN) + SW'(shift_code);
  assign smp_wide  = $signed({{2{smp[DW-1]}}, smp, {FB{1'b0}}});
  assign base_wide = $signed({{2{base_q[AW-1]}}, base_q});
  assign delta     = smp_wide - base_wide;
  assign step      = delta >>> shamt;
  assign base_sum  = base_wide + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      armed_q <= 1'b1;
    end else if (smp_valid) begin
      armed_q <= 1'b0;
      if (seed_take) base_q <= smp_wide[AW-1:0];
      else           base_q <= base_sum[AW-1:0];
    end else if (seed_req) begin
      armed_q <= 1'b1;
      base_q  <= '0;
    end
  end
endmodule

// File: rtl/hpf_sink.sv
module hpf_sink
  import tahp_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         use_filt,
  input  logic [W-1:0] raw_bus,
  input  logic [W-1:0] filt_bus,
  output logic [W-1:0] q
);
  src_sel_e sel;
  assign sel = src_sel_e'(use_filt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= (sel == SRC_FILT) ? filt_bus : raw_bus;
  end
endmodule

// File: rtl/tri_axis_hpf.sv
module tri_axis_hpf #(
  parameter int DW   = 8,
  parameter int NAX  = 3,
  parameter int FB   = 8,
  parameter int CW   = 2,
  parameter int NENG = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [NAX*DW-1:0]       smp_data,
  input  logic [CW-1:0]           cut_sel,
  input  logic                    flush,
  input  logic                    out_filt,
  input  logic [NENG-1:0]         eng_filt,
  output logic                    out_valid,
  output logic [NAX*DW-1:0]       out_data,
  output logic [NENG*NAX*DW-1:0]  eng_data
);
  localparam int BW = NAX * DW;

  logic [BW-1:0]  filt_bus;
  logic [NAX-1:0] seed_take;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    logic signed [DW-1:0] hp_a;
    hpf_axis #(.DW(DW), .FB(FB), .CW(CW)) u_axis (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .seed_req  (flush),
      .smp       (smp_data[a*DW +: DW]),
      .shift_code(cut_sel),
      .hp        (hp_a),
      .seed_take (seed_take[a])
    );
    assign filt_bus[a*DW +: DW] = hp_a;
  end

  hpf_sink #(.W(BW)) u_out_sink (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (smp_valid),
    .use_filt(out_filt),
    .raw_bus (smp_data),
    .filt_bus(filt_bus),
    .q       (out_data)
  );

  for (genvar e = 0; e < NENG; e++) begin : g_eng
    hpf_sink #(.W(BW)) u_eng_sink (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (smp_valid),
      .use_filt(eng_filt[e]),
      .raw_bus (smp_data),
      .filt_bus(filt_bus),
      .q       (eng_data[e*BW +: BW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= smp_valid;
  end
endmodule

// File: rtl/tahp_checker.sv
module tahp_checker #(
  parameter int DW   = 8,
  parameter int NAX  = 3,
  parameter int NENG = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   smp_valid,
  input logic [NAX*DW-1:0]      smp_data,
  input logic                   flush,
  input logic                   out_filt,
  input logic [NENG-1:0]        eng_filt,
  input logic                   out_valid,
  input logic [NAX*DW-1:0]      out_data,
  input logic [NENG*NAX*DW-1:0] eng_data,
  input logic [NAX*DW-1:0]      filt_bus,
  input logic [NAX-1:0]         seed_take
);
  localparam int BW = NAX * DW;

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(out_data) && $stable(eng_data)));
  assert_raw_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !out_filt) |=> (out_data == $past(smp_data)));
  assert_filt_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && out_filt) |=> (out_data == $past(filt_bus)));
  assert_flush_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (seed_take == {NAX{1'b1}}));
  assert_seed_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && flush) |-> (filt_bus == '0));

  for (genvar e = 0; e < NENG; e++) begin : g_eng_chk
    assert_eng_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !eng_filt[e]) |=> (eng_data[e*BW +: BW] == $past(smp_data)));
    assert_eng_filt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && eng_filt[e]) |=> (eng_data[e*BW +: BW] == $past(filt_bus)));
  end
endmodule

bind tri_axis_hpf tahp_checker #(.DW(DW), .NAX(NAX), .NENG(NENG)) u_tahp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .smp_data (smp_data),
  .flush    (flush),
  .out_filt (out_filt),
  .eng_filt (eng_filt),
  .out_valid(out_valid),
  .out_data (out_data),
  .eng_data (eng_data),
  .filt_bus (filt_bus),
  .seed_take(seed_take)
);

// File: tb/test_tri_axis_hpf.sv
`timescale 1ns/1ps
module test_tri_axis_hpf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic [1:0]  cut_sel = '0;
  logic        flush = 1'b0;
  logic        out_filt = 1'b0;
  logic [1:0]  eng_filt = '0;
  logic        out_valid;
  logic [23:0] out_data;
  logic [47:0] eng_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  int  m_base [3];
  bit  m_armed [3];
  logic [23:0] last_out;
  logic [47:0] last_eng;

  always #2.5 clk = ~clk;

  tri_axis_hpf i_tri_axis_hpf (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cut_sel(cut_sel), .flush(flush), .out_filt(out_filt), .eng_filt(eng_filt),
    .out_valid(out_valid), .out_data(out_data), .eng_data(eng_data)
  );

  function automatic int floor_div(int v, int k);
    int d = 1 << k;
    int q = v / d;
    if (v < 0 && q * d != v) q = q - 1;
    return q;
  endfunction

  function automatic int clip8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int sx8(logic [7:0] b);
    return int'($signed(b));
  endfunction

  task automatic chk(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample at next negedge
  task automatic step_cycle(bit v, logic [23:0] d, logic [1:0] cs, bit fl, bit of, logic [1:0] ef, string tag);
    logic [23:0] exp_raw, exp_filt, exp_out;
    logic [47:0] exp_eng;
    bit arm_now;
    exp_raw = d;
    for (int a = 0; a < 3; a++) begin
      int x = sx8(d[a*8 +: 8]);
      arm_now = m_armed[a] | fl;
      exp_filt[a*8 +: 8] = arm_now ? 8'd0 : 8'(clip8(x - floor_div(m_base[a], 8)));
    end
    exp_out = of ? exp_filt : exp_raw;
    for (int e = 0; e < 2; e++) exp_eng[e*24 +: 24] = ef[e] ? exp_filt : exp_raw;
    smp_valid = v; smp_data = d; cut_sel = cs; flush = fl; out_filt = of; eng_filt = ef;
    @(negedge clk);
    smp_valid = 1'b0; flush = 1'b0;
    if (v) begin
      chk(out_valid === 1'b1, {tag, " R2 out_valid"}, 48'(out_valid), 48'd1);
      chk(out_data === exp_out, {tag, " R3/R6 out_data"}, 48'(out_data), 48'(exp_out));
      chk(eng_data === exp_eng, {tag, " R7 eng_data"}, eng_data, exp_eng);
      for (int a = 0; a < 3; a++) begin
        int x = sx8(d[a*8 +: 8]);
        if (m_armed[a] | fl) m_base[a] = x * 256;
        else m_base[a] = m_base[a] + floor_div(x * 256 - m_base[a], 3 + int'(cs));
        m_armed[a] = 1'b0;
      end
    end else begin
      chk(out_valid === 1'b0, {tag, " R2 idle out_valid"}, 48'(out_valid), 48'd0);
      chk(out_data === last_out && eng_data === last_eng, {tag, " R2/R4 hold"},
          {out_data, 24'(eng_data)}, {last_out, 24'(last_eng)});
      if (fl) for (int a = 0; a < 3; a++) begin m_armed[a] = 1'b1; m_base[a] = 0; end
    end
    last_out = out_data; last_eng = eng_data;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    for (int a = 0; a < 3; a++) begin m_base[a] = 0; m_armed[a] = 1'b1; end
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_data === '0 && eng_data === '0, "R1 reset state",
        {out_valid, 23'(out_data), 24'(eng_data)}, 48'd0);
    rst_n = 1'b1;
    @(negedge clk);
    last_out = out_data; last_eng = eng_data;

    // R1/R5: first sample after reset seeds, filtered reads 0
    step_cycle(1, {8'd90, 8'hD0, 8'd17}, 2'd0, 0, 1, 2'b01, "R1 seed after reset");
    // R3: step response at each cutoff, R9 per-axis distinct data
    for (int c = 0; c < 4; c++) begin
      step_cycle(0, 24'h0, 2'd0, 1, 0, 2'b00, "R5 flush idle");
      step_cycle(1, {8'd0, 8'd0, 8'd0}, 2'(c), 0, 1, 2'b10, "R5 seed zero");
      for (int i = 0; i < 6; i++)
        step_cycle(1, {8'd100, 8'hCE, 8'd5}, 2'(c), 0, 1, 2'b11, "R3 step R9");
    end
    // R4: idle cycles with changing inputs and cutoff leave the state alone
    for (int i = 0; i < 5; i++)
      step_cycle(0, 24'($urandom), 2'(i), 0, 1, 2'b11, "R4 idle");
    step_cycle(1, {8'd100, 8'hCE, 8'd5}, 2'd1, 0, 1, 2'b00, "R4 after idle");
    // R8: saturation both ways
    step_cycle(1, {8'h80, 8'h7F, 8'h80}, 2'd3, 1, 1, 2'b11, "R5 flush with sample");
    step_cycle(1, {8'h7F, 8'h80, 8'h7F}, 2'd3, 0, 1, 2'b11, "R8 saturation");
    step_cycle(1, {8'h7F, 8'h80, 8'h00}, 2'd3, 0, 1, 2'b01, "R8 saturation hold");
    // R6/R7: all select combinations
    for (int s = 0; s < 8; s++)
      step_cycle(1, 24'($urandom), 2'd2, 0, s[2], s[1:0], "R6 R7 select");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 10) < 7;
      bit f = ($urandom % 20) == 0;
      step_cycle(v, 24'($urandom), 2'($urandom), f, 1'($urandom), 2'($urandom), "R3 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule